// File: doc/BRIEF.md
# Multiplexed Processor Bus Cycle Sequencer

This block runs the external bus cycles of a 16-bit processor with a 20-bit byte address. Three internal sources ask for cycles. A DMA engine can ask for memory or port reads and writes. The execution side can ask for the same four kinds of cycle and also for interrupt-acknowledge and halt. The prefetcher asks implicitly: it offers a fetch address together with the number of free bytes in its instruction queue. Every cycle follows one fixed four-clock shape. The first clock drives the address and the cycle-type status. The middle two clocks hold the read or write strobe. The last clock releases the strobe and returns the status to passive.

When no source is waiting, the sequencer sits in idle clocks. In idle it decides whether the data bus stays driven. It holds the last write data after a write cycle and lets the bus float after any other cycle. Read data is captured at the end of the third clock and shown on `rdata` during the fourth. When the cycle was a prefetch, a queue push pulse is raised at the same time. Each source learns that it was chosen from a one-hot grant that is valid in the first clock of its cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted, status is 111, rd_n and wr_n are high, dout_en is low and grant is 000.
- R2: During the first three clocks of a cycle, status carries the cycle code: interrupt-acknowledge 000, port read 001, port write 010, halt 011, prefetch 100, memory read 101, memory write 110. The source kind encodings are as follows. exe_kind uses 0 memory read, 1 memory write, 2 port read, 3 port write, 4 interrupt-acknowledge and 5 halt, and its values 6 and 7 mean memory read. dma_kind uses 0 to 3 with the same meanings as exe_kind.
- R3: In port read and port write cycles, address bits 19:16 are zero. In every other cycle, the full 20-bit requested address is placed on addr from the first to the fourth clock.
- R4: A cycle takes exactly four clocks (T1 to T4). Status is 111 in T4 and in every idle clock.
- R5: rd_n is low in T2 and T3 of memory read, port read and prefetch cycles, and only then. wr_n is low in T2 and T3 of memory and port writes, and only then. Interrupt-acknowledge and halt cycles drive no strobe.
- R6: For read-type cycles, din is sampled at the end of T3 and appears on rdata with rd_done high in T4. pf_push is high in T4 of a prefetch cycle and at no other time.
- R7: dout_en is high in T2 to T4 of a write cycle and low in T1. In an idle clock it is high, with dout holding the last write data, if the previous cycle was a write, and low otherwise.
- R8: When several sources wait at once, DMA is served first, then execution, then prefetch. grant is {dma, exe, prefetch}, is one-hot in T1 and is 000 in all other clocks.
- R9: A prefetch cycle starts only when pf_free is 2 or more.
- R10: A request that is present in T4 starts its T1 on the next clock, with no idle clock between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | DMA cycle request, held until granted |
| dma_kind | input | 2 | DMA cycle kind (R2 encoding) |
| dma_addr | input | 20 | DMA byte address |
| dma_wdata | input | 16 | DMA write data |
| exe_req | input | 1 | Execution-side cycle request, held until granted |
| exe_kind | input | 3 | Execution cycle kind (R2 encoding) |
| exe_addr | input | 20 | Execution byte address |
| exe_wdata | input | 16 | Execution write data |
| pf_free | input | 4 | Free bytes in the prefetch queue |
| pf_addr | input | 20 | Next prefetch address |
| din | input | 16 | Data bus input |
| status | output | 3 | Cycle-type status code |
| addr | output | 20 | Address lines |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dout | output | 16 | Data bus output value |
| dout_en | output | 1 | Data bus output enable |
| grant | output | 3 | One-hot grant {dma, exe, prefetch}, valid in T1 |
| rdata | output | 16 | Captured read data |
| rd_done | output | 1 | Read data valid (T4 of a read) |
| pf_push | output | 1 | Prefetch queue write pulse |

## Verification
The hardest situation to reach from the ports is a T4 in which all three sources are pending together. In that clock the priority decision and the back-to-back start coincide. The prefetcher asks implicitly whenever space exists, so the bench holds pf_free at zero through the directed part. It then raises DMA, execution and a large free count on one edge while the bus is idle. The second and third grants then land on T4 boundaries, and their exact clocks are checked. The idle drive after a write followed by a read, and the upper address bits on port cycles, are covered both by directed cycles and by long randomized request streams. A behavioural model in the bench compares all of these on every clock.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    K_MRD  = 3'd0,
    K_MWR  = 3'd1,
    K_IORD = 3'd2,
    K_IOWR = 3'd3,
    K_INTA = 3'd4,
    K_HALT = 3'd5,
    K_PF   = 3'd6
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PF   = 2'd1,
    SRC_EXE  = 2'd2,
    SRC_DMA  = 2'd3
  } src_e;

  localparam logic [2:0] ST_PASSIVE = 3'b111;

  // Cycle-type code driven on the status lines.
  function automatic logic [2:0] status_of(kind_e k);
    case (k)
      K_INTA:  status_of = 3'b000;
      K_IORD:  status_of = 3'b001;
      K_IOWR:  status_of = 3'b010;
      K_HALT:  status_of = 3'b011;
      K_PF:    status_of = 3'b100;
      K_MRD:   status_of = 3'b101;
      K_MWR:   status_of = 3'b110;
      default: status_of = ST_PASSIVE;
    endcase
  endfunction

  function automatic logic is_rd(kind_e k);
    is_rd = (k == K_MRD) || (k == K_IORD) || (k == K_PF);
  endfunction

  function automatic logic is_wr(kind_e k);
    is_wr = (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic is_io(kind_e k);
    is_io = (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic kind_e from_exe(logic [2:0] c);
    case (c)
      3'd1:    from_exe = K_MWR;
      3'd2:    from_exe = K_IORD;
      3'd3:    from_exe = K_IOWR;
      3'd4:    from_exe = K_INTA;
      3'd5:    from_exe = K_HALT;
      default: from_exe = K_MRD;
    endcase
  endfunction

  function automatic kind_e from_dma(logic [1:0] c);
    from_dma = from_exe({1'b0, c});
  endfunction

endpackage

// File: rtl/bcs_arbiter.sv
module bcs_arbiter
  import bcs_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int QW     = 4,
  parameter int PF_MIN = 2,
  parameter int IO_HI  = 4
) (
  input  logic          dma_req,
  input  logic [1:0]    dma_kind,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  input  logic          exe_req,
  input  logic [2:0]    exe_kind,
  input  logic [AW-1:0] exe_addr,
  input  logic [DW-1:0] exe_wdata,
  input  logic [QW-1:0] pf_free,
  input  logic [AW-1:0] pf_addr,
  output logic          pick_vld,
  output src_e          pick_src,
  output kind_e         pick_kind,
  output logic [AW-1:0] pick_addr,
  output logic [DW-1:0] pick_wdata
);

  localparam int NSRC = 3;
  localparam logic [QW-1:0] PF_MIN_Q = QW'(PF_MIN);

  // Port cycles clear the top address bits.
  function automatic logic [AW-1:0] place_addr(kind_e k, logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    if (is_io(k)) r[AW-1 -: IO_HI] = '0;
    return r;
  endfunction

  // Index 0 lowest priority, NSRC-1 highest.
  logic          req_v   [NSRC];
  kind_e         kind_v  [NSRC];
  logic [AW-1:0] addr_v  [NSRC];
  logic [DW-1:0] wdata_v [NSRC];
  logic          pf_ok;

  assign pf_ok = (pf_free >= PF_MIN_Q);

  always_comb begin
    req_v[0]   = pf_ok;
    kind_v[0]  = K_PF;
    addr_v[0]  = pf_addr;
    wdata_v[0] = '0;
    req_v[1]   = exe_req;
    kind_v[1]  = from_exe(exe_kind);
    addr_v[1]  = exe_addr;
    wdata_v[1] = exe_wdata;
    req_v[2]   = dma_req;
    kind_v[2]  = from_dma(dma_kind);
    addr_v[2]  = dma_addr;
    wdata_v[2] = dma_wdata;
  end

  always_comb begin
    pick_vld   = 1'b0;
    pick_src   = SRC_NONE;
    pick_kind  = K_MRD;
    pick_addr  = '0;
    pick_wdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_v[i]) begin
        pick_vld   = 1'b1;
        pick_src   = src_e'(2'(i + 1));
        pick_kind  = kind_v[i];
        pick_addr  = place_addr(kind_v[i], addr_v[i]);
        pick_wdata = wdata_v[i];
      end
    end
  end

endmodule

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pick_vld,
  output phase_e phase,
  output logic   accept
);

  // A new cycle may begin from idle or straight out of T4.
  assign accept = pick_vld && ((phase == PH_IDLE) || (phase == PH_T4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE, PH_T4: phase <= accept ? PH_T1 : PH_IDLE;
        PH_T1:          phase <= PH_T2;
        PH_T2:          phase <= PH_T3;
        PH_T3:          phase <= PH_T4;
        default:        phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcs_bus_drive.sv
module bcs_bus_drive
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          accept,
  input  src_e          pick_src,
  input  kind_e         pick_kind,
  input  logic [AW-1:0] pick_addr,
  input  logic [DW-1:0] pick_wdata,
  input  logic [DW-1:0] din,
  output logic [2:0]    status,
  output logic [AW-1:0] addr,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic [2:0]    grant,
  output logic [DW-1:0] rdata,
  output logic          rd_done,
  output logic          pf_push
);

  kind_e         cur_kind;
  src_e          cur_src;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic          in_status, in_strobe, in_data;

  // The cycle registers keep the last cycle during idle, which sets idle drive.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_kind  <= K_MRD;
      cur_src   <= SRC_NONE;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        cur_kind  <= pick_kind;
        cur_src   <= pick_src;
        cur_addr  <= pick_addr;
        cur_wdata <= pick_wdata;
      end
      if ((phase == PH_T3) && is_rd(cur_kind)) rdata <= din;
    end
  end

  assign in_status = (phase == PH_T1) || (phase == PH_T2) || (phase == PH_T3);
  assign in_strobe = (phase == PH_T2) || (phase == PH_T3);
  assign in_data   = in_strobe || (phase == PH_T4);

  always_comb begin
    status  = in_status ? status_of(cur_kind) : ST_PASSIVE;
    addr    = cur_addr;
    rd_n    = !(in_strobe && is_rd(cur_kind));
    wr_n    = !(in_strobe && is_wr(cur_kind));
    dout_en = is_wr(cur_kind) && (in_data || (phase == PH_IDLE));
    dout    = dout_en ? cur_wdata : '0;
    rd_done = (phase == PH_T4) && is_rd(cur_kind);
    pf_push = rd_done && (cur_src == SRC_PF);
    grant   = 3'b000;
    if (phase == PH_T1) begin
      case (cur_src)
        SRC_DMA: grant = 3'b100;
        SRC_EXE: grant = 3'b010;
        SRC_PF:  grant = 3'b001;
        default: grant = 3'b000;
      endcase
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int QW     = 4,
  parameter int PF_MIN = 2,
  parameter int IO_HI  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_req,
  input  logic [1:0]    dma_kind,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  input  logic          exe_req,
  input  logic [2:0]    exe_kind,
  input  logic [AW-1:0] exe_addr,
  input  logic [DW-1:0] exe_wdata,
  input  logic [QW-1:0] pf_free,
  input  logic [AW-1:0] pf_addr,
  input  logic [DW-1:0] din,
  output logic [2:0]    status,
  output logic [AW-1:0] addr,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic [2:0]    grant,
  output logic [DW-1:0] rdata,
  output logic          rd_done,
  output logic          pf_push
);

  logic          pick_vld;
  src_e          pick_src;
  kind_e         pick_kind;
  logic [AW-1:0] pick_addr;
  logic [DW-1:0] pick_wdata;
  phase_e        phase;
  logic          accept;

  // Named phase events for the checker.
  logic ph_idle, ph_t1, ph_t4;
  assign ph_idle = (phase == PH_IDLE);
  assign ph_t1   = (phase == PH_T1);
  assign ph_t4   = (phase == PH_T4);

  bcs_arbiter #(
    .AW(AW), .DW(DW), .QW(QW), .PF_MIN(PF_MIN), .IO_HI(IO_HI)
  ) u_arb (
    .dma_req   (dma_req),
    .dma_kind  (dma_kind),
    .dma_addr  (dma_addr),
    .dma_wdata (dma_wdata),
    .exe_req   (exe_req),
    .exe_kind  (exe_kind),
    .exe_addr  (exe_addr),
    .exe_wdata (exe_wdata),
    .pf_free   (pf_free),
    .pf_addr   (pf_addr),
    .pick_vld  (pick_vld),
    .pick_src  (pick_src),
    .pick_kind (pick_kind),
    .pick_addr (pick_addr),
    .pick_wdata(pick_wdata)
  );

  bcs_phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pick_vld(pick_vld),
    .phase   (phase),
    .accept  (accept)
  );

  bcs_bus_drive #(.AW(AW), .DW(DW)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .accept    (accept),
    .pick_src  (pick_src),
    .pick_kind (pick_kind),
    .pick_addr (pick_addr),
    .pick_wdata(pick_wdata),
    .din       (din),
    .status    (status),
    .addr      (addr),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .dout      (dout),
    .dout_en   (dout_en),
    .grant     (grant),
    .rdata     (rdata),
    .rd_done   (rd_done),
    .pf_push   (pf_push)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int QW     = 4,
  parameter int PF_MIN = 2,
  parameter int IO_HI  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    status,
  input logic [AW-1:0] addr,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic [2:0]    grant,
  input logic          rd_done,
  input logic [QW-1:0] pf_free,
  input logic          ph_idle,
  input logic          ph_t1,
  input logic          ph_t4
);

  localparam logic [QW-1:0] PF_MIN_Q = QW'(PF_MIN);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R5
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);

  // R5
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |=> rd_n);

  // R4
  passive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (status == 3'b111));

  // R3
  io_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 3'b001) || (status == 3'b010)) |-> (addr[AW-1 -: IO_HI] == '0));

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant != 3'b000) -> ph_t1));

  // R7
  wr_release_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> dout_en);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_idle && $past(ph_t4) && $past(dout_en)) |-> (dout_en && $stable(dout)));

  // R9
  pf_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[0] |-> ($past(pf_free) >= PF_MIN_Q));

  // R6
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(!rd_n));

endmodule

bind bus_cycle_seq bcs_checker #(
  .AW(AW), .DW(DW), .QW(QW), .PF_MIN(PF_MIN), .IO_HI(IO_HI)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .status (status),
  .addr   (addr),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .dout   (dout),
  .dout_en(dout_en),
  .grant  (grant),
  .rd_done(rd_done),
  .pf_free(pf_free),
  .ph_idle(ph_idle),
  .ph_t1  (ph_t1),
  .ph_t4  (ph_t4)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        dma_req, exe_req;
  logic [1:0]  dma_kind;
  logic [2:0]  exe_kind;
  logic [19:0] dma_addr, exe_addr, pf_addr;
  logic [15:0] dma_wdata, exe_wdata, din;
  logic [3:0]  pf_free;
  logic [2:0]  status, grant;
  logic [19:0] addr;
  logic        rd_n, wr_n, dout_en, rd_done, pf_push;
  logic [15:0] dout, rdata;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n),
    .dma_req(dma_req), .dma_kind(dma_kind), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .exe_req(exe_req), .exe_kind(exe_kind), .exe_addr(exe_addr), .exe_wdata(exe_wdata),
    .pf_free(pf_free), .pf_addr(pf_addr), .din(din),
    .status(status), .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .dout(dout),
    .dout_en(dout_en), .grant(grant), .rdata(rdata), .rd_done(rd_done), .pf_push(pf_push)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired got %0d exp %0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- reference model ----------------
  // m_ph: 0 idle, 1..4 = T1..T4; m_code is the status code of the cycle.
  logic [2:0]  m_ph;
  logic [2:0]  m_code;
  logic [2:0]  m_src;   // grant bits {dma, exe, pf}
  logic [19:0] m_addr;
  logic [15:0] m_wd;
  logic [15:0] m_rdata;

  function automatic logic [2:0] code_of(input logic [2:0] k);
    case (k)
      3'd1:    return 3'b110;
      3'd2:    return 3'b001;
      3'd3:    return 3'b010;
      3'd4:    return 3'b000;
      3'd5:    return 3'b011;
      default: return 3'b101;
    endcase
  endfunction

  function automatic bit rdc(input logic [2:0] c);
    return (c == 3'b101) || (c == 3'b001) || (c == 3'b100);
  endfunction

  function automatic bit wrc(input logic [2:0] c);
    return (c == 3'b110) || (c == 3'b010);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 3'd0; m_code = 3'b101; m_src = 3'b000;
      m_addr = '0; m_wd = '0; m_rdata = '0;
    end else begin
      if (m_ph == 3'd3 && rdc(m_code)) m_rdata = din;
      if (m_ph == 3'd0 || m_ph == 3'd4) begin
        m_ph = 3'd1;
        if (dma_req) begin
          m_src = 3'b100; m_code = code_of({1'b0, dma_kind}); m_addr = dma_addr; m_wd = dma_wdata;
        end else if (exe_req) begin
          m_src = 3'b010; m_code = code_of(exe_kind); m_addr = exe_addr; m_wd = exe_wdata;
        end else if (pf_free >= 4'd2) begin
          m_src = 3'b001; m_code = 3'b100; m_addr = pf_addr; m_wd = '0;
        end else begin
          m_ph = 3'd0;
        end
        if (m_ph == 3'd1 && (m_code == 3'b001 || m_code == 3'b010)) m_addr[19:16] = 4'h0;
      end else begin
        m_ph = m_ph + 3'd1;
      end
    end
  end

  // Compare outputs with the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0]  e_st;
      logic        e_rdn, e_wrn, e_den, e_done;
      logic [15:0] e_dout;
      logic [2:0]  e_gnt;
      e_st   = (m_ph >= 3'd1 && m_ph <= 3'd3) ? m_code : 3'b111;
      e_rdn  = !(rdc(m_code) && (m_ph == 3'd2 || m_ph == 3'd3));
      e_wrn  = !(wrc(m_code) && (m_ph == 3'd2 || m_ph == 3'd3));
      e_den  = wrc(m_code) && (m_ph >= 3'd2 || m_ph == 3'd0);
      e_dout = e_den ? m_wd : 16'h0;
      e_gnt  = (m_ph == 3'd1) ? m_src : 3'b000;
      e_done = (m_ph == 3'd4) && rdc(m_code);
      // R2 R4
      chk(status == e_st, "R2/R4", "status", 32'(status), 32'(e_st));
      // R3
      if (m_ph != 3'd0) chk(addr == m_addr, "R3", "addr", 32'(addr), 32'(m_addr));
      // R5
      chk(rd_n == e_rdn && wr_n == e_wrn, "R5", "strobes", 32'({rd_n, wr_n}), 32'({e_rdn, e_wrn}));
      // R7
      chk(dout_en == e_den && dout == e_dout, "R7", "drive", 32'({dout_en, dout}), 32'({e_den, e_dout}));
      // R8
      chk(grant == e_gnt, "R8", "grant", 32'(grant), 32'(e_gnt));
      // R6
      chk(rd_done == e_done && pf_push == (e_done && m_src == 3'b001), "R6", "done/push",
          32'({rd_done, pf_push}), 32'({e_done, e_done && m_src == 3'b001}));
      if (e_done) chk(rdata == m_rdata, "R6", "rdata", 32'(rdata), 32'(m_rdata));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk);
    if (grant[2]) dma_req = 1'b0;
    if (grant[1]) exe_req = 1'b0;
    din = 16'($urandom);
  endtask

  task automatic exe_go(input logic [2:0] k, input logic [19:0] a, input logic [15:0] wd);
    exe_req = 1'b1; exe_kind = k; exe_addr = a; exe_wdata = wd;
    do step(); while (exe_req);
  endtask

  initial begin
    rst_n = 1'b0; dma_req = 1'b0; exe_req = 1'b0;
    dma_kind = '0; exe_kind = '0; dma_addr = '0; exe_addr = '0; pf_addr = 20'h00100;
    dma_wdata = '0; exe_wdata = '0; din = '0; pf_free = 4'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 3'b111 && rd_n && wr_n && !dout_en && grant == 3'b000, "R1", "reset outputs",
        32'({status, rd_n, wr_n, dout_en, grant}), 32'({3'b111, 1'b1, 1'b1, 1'b0, 3'b000}));
    rst_n = 1'b1;
    step();

    // every kind through the execution side (R2, R3, R5)
    exe_go(3'd0, 20'hABCDE, 16'h0);
    exe_go(3'd2, 20'hF1234, 16'h0);
    exe_go(3'd1, 20'h12345, 16'hBEEF);
    repeat (6) step();
    // R7 idle after write keeps the data driven
    chk(dout_en && dout == 16'hBEEF, "R7", "idle after write",
        32'({dout_en, dout}), 32'({1'b1, 16'hBEEF}));
    exe_go(3'd3, 20'hE5678, 16'h1357);
    exe_go(3'd4, 20'h00000, 16'h0);
    exe_go(3'd5, 20'h00000, 16'h0);
    exe_go(3'd7, 20'h54321, 16'h0);
    repeat (6) step();
    // R7 idle after read floats the bus
    chk(!dout_en, "R7", "idle after read", 32'(dout_en), 32'(0));

    // R8 / R10: three sources collide while idle
    dma_req = 1'b1; dma_kind = 2'd1; dma_addr = 20'h3AAAA; dma_wdata = 16'hD00D;
    exe_req = 1'b1; exe_kind = 3'd0; exe_addr = 20'h4BBBB;
    pf_free = 4'd4; pf_addr = 20'h0C0C0;
    step();
    chk(grant == 3'b100, "R8", "first grant", 32'(grant), 32'(3'b100));
    repeat (4) step();
    chk(grant == 3'b010, "R10", "exe grant right after T4", 32'(grant), 32'(3'b010));
    repeat (4) step();
    chk(grant == 3'b001, "R8", "prefetch last", 32'(grant), 32'(3'b001));
    pf_free = 4'd1;
    repeat (6) step();

    // R9 prefetch needs two free bytes
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        step();
        if (grant[0]) seen = 1'b1;
      end
      chk(!seen, "R9", "prefetch with one free byte", 32'(seen), 32'(0));
    end
    pf_free = 4'd2;
    step();
    chk(grant == 3'b001, "R9", "prefetch with two free bytes", 32'(grant), 32'(3'b001));
    pf_free = 4'd0;
    repeat (6) step();

    // randomized request streams
    for (int n = 0; n < 4000; n++) begin
      step();
      if (!dma_req && ($urandom % 7 == 0)) begin
        dma_req = 1'b1; dma_kind = 2'($urandom); dma_addr = 20'($urandom); dma_wdata = 16'($urandom);
      end
      if (!exe_req && ($urandom % 5 == 0)) begin
        exe_req = 1'b1; exe_kind = 3'($urandom); exe_addr = 20'($urandom); exe_wdata = 16'($urandom);
      end
      if ($urandom % 9 == 0) pf_free = 4'($urandom % 5);
      pf_addr = 20'($urandom);
    end
    dma_req = 1'b0; exe_req = 1'b0; pf_free = 4'd0;
    repeat (10) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule